// File: doc/BRIEF.md
# Distributed-Arithmetic Carry-Save Inner Product

This block forms the dot product of four signed weights with four signed samples without any multiplier. When a start strobe arrives, it captures the samples and builds a register table. Each table entry holds the sum of the samples picked out by the bits of its address. The weights are captured at the same moment. On each following clock, one bit position taken across all four weights forms the table address. The selected partial sum then enters a carry-save accumulator. The accumulator halves its running value before every addition and keeps each bit it shifts out, so no precision is lost.

The weights are two's complement, so the slice taken from the sign bit must be subtracted. While that slice is addressed, the table output is bit-inverted, and the missing +1 goes in as the carry-in of a final adder. The final adder merges the sum word, the carry word (which carries twice the weight of the sum word) and the collected low bits into a full-precision signed result. A parameter can leave the final adder out, in which case a downstream stage resolves the two words.

Top module: `dacs_inner_product`

## Requirements
- R1: While reset is held, `done`, `sum_word` and `carry_word` are driven to zero, and they are still zero on the first cycle after release.
- R2: If `start` is sampled high on clock edge E0, `done` is high for exactly one cycle, from edge E(WL) to edge E(WL+1), and is low after every edge in between.
- R3: While `done` is high, and until the next start, `result` holds the signed product sum of sample j (bits `x_flat[j*XW +: XW]`) and weight j (bits `w_flat[j*WL +: WL]`) over j = 0..3, as an RW = XW+2+WL bit two's-complement number.
- R4: A weight bit at the sign position counts with negative weight, so the most negative weight value gives exact results, including the largest positive product magnitude.
- R5: When `done` is high, the signed `sum_word` plus twice the signed `carry_word` plus one equals the exact result arithmetically shifted right by WL-1.
- R6: An all-zero weight slice selects a table value of zero, so zero weights give a result of 0 whatever the samples are.
- R7: A start that arrives while a product is in progress drops that product. No `done` is raised for it, and the new operands complete WL cycles after the new start.
- R8: Samples and weights are taken only on the start cycle. Changing them later has no effect on the result.
- R9: While the block is idle and `start` is low, `sum_word`, `carry_word` and `result` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one weight bit slice per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Captures operands and begins a product |
| x_flat | input | NPTS*XW | Four signed samples, sample j at bits j*XW and up |
| w_flat | input | NPTS*WL | Four signed weights, weight j at bits j*WL and up |
| sum_word | output | XW+2 | Carry-save sum word, aligned at 2^(WL-1) |
| carry_word | output | XW+2 | Carry-save carry word, twice the weight of the sum word |
| done | output | 1 | One-cycle pulse when the words are final |
| result | output | XW+2+WL | Resolved signed inner product |

## Verification
The assertions assume that `start` can arrive in any cycle, including a restart mid-product, and that `rst_n` is held low for at least one clock before operands are applied. They also assume that operand inputs may change freely outside the start cycle. The stimulus uses every freedom that assumption allows. It scrambles samples and weights on the cycle after each start, restarts one product partway through, and leaves idle gaps so the hold property is exercised. The random operands span the full signed range of both widths, and directed cases pin the most negative weights and samples, zero weights and zero samples.

// File: rtl/dacs_pkg.sv
// Shared definitions for the distributed-arithmetic inner product.
// Assumes nothing beyond a two's-complement datapath.
package dacs_pkg;

    // Smallest weight width the sequencer and low-bit collector support.
    parameter int unsigned DACS_MIN_WL = 2;

    // Sequencer phase.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_phase_t;

endpackage

// File: rtl/dacs_da_table.sv
// Partial-sum table: entry k holds the sum of every sample j whose bit j
// in k is set. Entry 0 is not stored; it reads as zero. The read value is
// bit-inverted when 'negate' is high (sign slice of the weights).
// Assumes samples are two's complement and EW >= XW + clog2(NPTS).
module dacs_da_table #(
    parameter int NPTS = 4,
    parameter int XW   = 8,
    parameter int EW   = XW + $clog2(NPTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NPTS*XW-1:0]   x_flat,
    input  logic [NPTS-1:0]      addr,
    input  logic                 negate,
    output logic [EW-1:0]        tap
);
    localparam int TSZ = 1 << NPTS;

    logic [EW-1:0] tbl [TSZ];

    // The zero address has no register behind it.
    assign tbl[0] = '0;

    for (genvar k = 1; k < TSZ; k++) begin : g_ent
        logic [EW-1:0] fill_v;
        logic [EW-1:0] ent_q;

        // Sum of the samples selected by the bits of k.
        always_comb begin
            fill_v = '0;
            for (int j = 0; j < NPTS; j++) begin
                if (((k >> j) & 1) != 0) begin
                    fill_v = fill_v + EW'($signed(x_flat[j*XW +: XW]));
                end
            end
        end

        // Capture the entry on a load, clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (load) begin
                ent_q <= fill_v;
            end
        end

        assign tbl[k] = ent_q;
    end

    // Read one entry, invert every bit for the sign slice.
    assign tap = tbl[addr] ^ {EW{negate}};

endmodule

// File: rtl/dacs_seq.sv
// Slice sequencer: after a start it steps the slice index from the least
// significant weight bit to the sign bit, one per cycle. It flags the sign
// slice and pulses 'done' in the cycle after that slice. A start while
// running restarts from slice 0.
// Assumes WL >= 2.
module dacs_seq
    import dacs_pkg::*;
#(
    parameter int WL = 8,
    parameter int IW = (WL > 1) ? $clog2(WL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          msb_slice,
    output logic [IW-1:0] slice_idx,
    output logic          done
);
    localparam logic [IW-1:0] LAST = IW'(WL - 1);

    seq_phase_t phase_q;

    // Phase, slice index and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= SEQ_IDLE;
            slice_idx <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                phase_q   <= SEQ_RUN;
                slice_idx <= '0;
            end else if (phase_q == SEQ_RUN) begin
                if (slice_idx == LAST) begin
                    phase_q <= SEQ_IDLE;
                    done    <= 1'b1;
                end else begin
                    slice_idx <= slice_idx + 1'b1;
                end
            end
        end
    end

    assign busy      = (phase_q == SEQ_RUN);
    assign msb_slice = busy && (slice_idx == LAST);

endmodule

// File: rtl/dacs_csa_acc.sv
// Right-shifting carry-save accumulator. Each step halves the pair
// (sum + 2*carry), adds the new table value and keeps the bit shifted out
// of the sum word, which is exact because the carry word holds no weight-1
// bit. Both words stay EW bits wide with sign extension kept exact.
// Assumes 'clear' happens before the first step of each product.
module dacs_csa_acc #(
    parameter int EW = 10,
    parameter int WL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [EW-1:0] addend,
    output logic [EW-1:0] sum_q,
    output logic [EW-1:0] cy_q,
    output logic [WL-2:0] low_q
);
    logic [EW-1:0] s_in;
    logic [EW-1:0] fa_v;
    logic [EW-1:0] mj_v;
    logic [WL-2:0] low_next;

    // Halve the pair: arithmetic shift of the sum word, carry word drops its x2.
    assign s_in = EW'($signed(sum_q) >>> 1);

    // Bitwise full-adder row over the three operands.
    always_comb begin
        fa_v     = s_in ^ cy_q ^ addend;
        mj_v     = (s_in & cy_q) | (s_in & addend) | (cy_q & addend);
        low_next = (WL-1)'({sum_q[0], low_q} >> 1);
    end

    // Carry-save state and collected low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cy_q  <= '0;
            low_q <= '0;
        end else if (clear) begin
            sum_q <= '0;
            cy_q  <= '0;
            low_q <= '0;
        end else if (step) begin
            sum_q <= fa_v;
            cy_q  <= mj_v;
            low_q <= low_next;
        end
    end

endmodule

// File: rtl/dacs_final_add.sv
// Final resolver: sum + 2*carry + 1 (the +1 finishes the negation of the
// sign slice), then appends the low bits collected during the shifts.
// Assumes the true result fits in EW+WL signed bits.
module dacs_final_add #(
    parameter int EW = 10,
    parameter int WL = 8
) (
    input  logic [EW-1:0]    sum_w,
    input  logic [EW-1:0]    cy_w,
    input  logic [WL-2:0]    low_w,
    output logic [EW+WL-1:0] value
);
    logic [EW:0] hi_v;

    // One carry-propagate add with forced carry-in.
    assign hi_v  = {sum_w[EW-1], sum_w} + {cy_w, 1'b0} + (EW+1)'(1);
    assign value = {hi_v, low_w};

endmodule

// File: rtl/dacs_inner_product.sv
// Four-point (NPTS) inner product by distributed arithmetic with carry-save
// accumulation. Start captures samples into the partial-sum table and
// latches the weights. WL cycles later 'done' pulses and the words and the
// resolved result are final; they hold until the next start.
// Assumes two's-complement samples and weights, WL >= 2.
module dacs_inner_product
    import dacs_pkg::*;
#(
    parameter int NPTS         = 4,
    parameter int XW           = 8,
    parameter int WL           = 8,
    parameter bit HAS_RESOLVER = 1'b1,
    parameter int EW           = XW + $clog2(NPTS),
    parameter int RW           = EW + WL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NPTS*XW-1:0] x_flat,
    input  logic [NPTS*WL-1:0] w_flat,
    output logic [EW-1:0]      sum_word,
    output logic [EW-1:0]      carry_word,
    output logic               done,
    output logic [RW-1:0]      result
);
    localparam int IW = (WL > 1) ? $clog2(WL) : 1;

    logic [NPTS-1:0][WL-1:0] w_q;
    logic [NPTS-1:0]         slice_addr;
    logic [IW-1:0]           slice_idx;
    logic                    busy;
    logic                    msb_slice;
    logic [EW-1:0]           tap;
    logic [WL-2:0]           low_bits;

    // Latch the weights on start; they are read one bit slice at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else if (start) begin
            w_q <= w_flat;
        end
    end

    // Bit j of the table address is the current bit of weight j.
    for (genvar j = 0; j < NPTS; j++) begin : g_addr
        assign slice_addr[j] = w_q[j][slice_idx];
    end

    dacs_seq #(.WL(WL), .IW(IW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (busy),
        .msb_slice (msb_slice),
        .slice_idx (slice_idx),
        .done      (done)
    );

    dacs_da_table #(.NPTS(NPTS), .XW(XW), .EW(EW)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .x_flat (x_flat),
        .addr   (slice_addr),
        .negate (msb_slice),
        .tap    (tap)
    );

    dacs_csa_acc #(.EW(EW), .WL(WL)) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .step   (busy),
        .addend (tap),
        .sum_q  (sum_word),
        .cy_q   (carry_word),
        .low_q  (low_bits)
    );

    if (HAS_RESOLVER) begin : g_res
        dacs_final_add #(.EW(EW), .WL(WL)) fin_i (
            .sum_w (sum_word),
            .cy_w  (carry_word),
            .low_w (low_bits),
            .value (result)
        );
    end else begin : g_nores
        assign result = '0;
    end

endmodule

// File: rtl/dacs_ip_checker.sv
// Protocol and timing properties of the inner product, bound to the top.
// Assumes rst_n is low for at least one clock at the start of time.
module dacs_ip_checker #(
    parameter int WL = 8,
    parameter int EW = 10,
    parameter int RW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [EW-1:0] sum_word,
    input logic [EW-1:0] carry_word,
    input logic [RW-1:0] result
);
    localparam int CW = $clog2(WL + 2);
    localparam logic [CW-1:0] CMAX = CW'(WL + 1);

    logic [CW-1:0] since_q;

    // Cycles since the last start, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            since_q <= '0;
        end else if (since_q != CMAX) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!done && sum_word == '0 && carry_word == '0));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == CW'(WL)));

    p_start_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(sum_word) && $stable(carry_word) && $stable(result)));

endmodule

bind dacs_inner_product dacs_ip_checker #(.WL(WL), .EW(EW), .RW(RW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .sum_word   (sum_word),
    .carry_word (carry_word),
    .result     (result)
);

// File: tb/dacs_inner_product_tb.sv
module dacs_inner_product_tb_top;
    localparam int NPTS       = 4;
    localparam int XW         = 8;
    localparam int WL         = 8;
    localparam int EW         = XW + 2;
    localparam int RW         = EW + WL;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [NPTS*XW-1:0] x_flat = '0;
    logic [NPTS*WL-1:0] w_flat = '0;
    logic [EW-1:0]      sum_word;
    logic [EW-1:0]      carry_word;
    logic               done;
    logic [RW-1:0]      result;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dacs_inner_product #(.NPTS(NPTS), .XW(XW), .WL(WL)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .x_flat     (x_flat),
        .w_flat     (w_flat),
        .sum_word   (sum_word),
        .carry_word (carry_word),
        .done       (done),
        .result     (result)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint dot(input int xs[NPTS], input int ws[NPTS]);
        longint acc = 0;
        for (int j = 0; j < NPTS; j++) acc += longint'(xs[j]) * longint'(ws[j]);
        return acc;
    endfunction

    function automatic int rnd_signed(input int width);
        return int'($urandom_range(0, (1 << width) - 1)) - (1 << (width - 1));
    endfunction

    // Drive operands with start for one cycle, then scramble them (R8).
    task automatic launch(input int xs[NPTS], input int ws[NPTS]);
        @(negedge clk);
        for (int j = 0; j < NPTS; j++) begin
            x_flat[j*XW +: XW] = XW'(xs[j]);
            w_flat[j*WL +: WL] = WL'(ws[j]);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        x_flat = (NPTS*XW)'({$urandom, $urandom});
        w_flat = (NPTS*WL)'({$urandom, $urandom});
    endtask

    // Wait out the product after launch and check timing, result and words.
    task automatic finish_op(input int xs[NPTS], input int ws[NPTS], input string tag);
        longint exp_v = dot(xs, ws);
        longint got_v;
        longint words_v;
        int early = 0;
        for (int i = 1; i < WL; i++) begin
            @(negedge clk);
            if (done) early++;
        end
        chk(early == 0, {"R2 no early done ", tag}, early, 0);
        @(negedge clk);
        chk(done == 1'b1, {"R2 done after WL cycles ", tag}, longint'(done), 1);
        got_v = longint'($signed(result));
        chk(got_v == exp_v, {"R3 R8 result ", tag}, got_v, exp_v);
        words_v = longint'($signed(sum_word)) + 2 * longint'($signed(carry_word)) + 1;
        chk(words_v == (exp_v >>> (WL - 1)), {"R5 words ", tag}, words_v, exp_v >>> (WL - 1));
        @(negedge clk);
        chk(done == 1'b0, {"R2 single pulse ", tag}, longint'(done), 0);
        got_v = longint'($signed(result));
        chk(got_v == exp_v, {"R3 result held ", tag}, got_v, exp_v);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int xs[NPTS];
        int ws[NPTS];
        int xb[NPTS];
        int wb[NPTS];
        logic [EW-1:0] s_cap;
        logic [EW-1:0] c_cap;
        logic [RW-1:0] r_cap;
        int early;

        void'($urandom(32'd20240611));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: values during reset.
        chk(done == 1'b0 && sum_word == '0 && carry_word == '0, "R1 in reset",
            longint'(sum_word) + longint'(carry_word) + longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && sum_word == '0 && carry_word == '0, "R1 after release",
            longint'(sum_word) + longint'(carry_word) + longint'(done), 0);

        // R4: most negative weights and samples, largest positive product.
        for (int j = 0; j < NPTS; j++) begin xs[j] = -128; ws[j] = -128; end
        launch(xs, ws); finish_op(xs, ws, "R4 min*min");
        // R4: most negative weights against largest samples.
        for (int j = 0; j < NPTS; j++) begin xs[j] = 127; ws[j] = -128; end
        launch(xs, ws); finish_op(xs, ws, "R4 max*min");
        // R4: largest weights against most negative samples.
        for (int j = 0; j < NPTS; j++) begin xs[j] = -128; ws[j] = 127; end
        launch(xs, ws); finish_op(xs, ws, "R4 min*max");
        // R6: zero weights select the zero table entry every slice.
        for (int j = 0; j < NPTS; j++) begin xs[j] = rnd_signed(XW); ws[j] = 0; end
        launch(xs, ws); finish_op(xs, ws, "R6 zero weights");
        // R6: zero samples with nonzero weights.
        for (int j = 0; j < NPTS; j++) begin xs[j] = 0; ws[j] = rnd_signed(WL); end
        launch(xs, ws); finish_op(xs, ws, "R6 zero samples");
        // R4: one negative unit weight against mixed samples.
        xs = '{5, -7, 100, -128}; ws = '{-1, 1, 0, -128};
        launch(xs, ws); finish_op(xs, ws, "R4 mixed signs");

        // R9: idle hold after completion.
        s_cap = sum_word; c_cap = carry_word; r_cap = result;
        repeat (6) @(negedge clk);
        chk(sum_word == s_cap && carry_word == c_cap && result == r_cap, "R9 idle hold",
            longint'($signed(result)), longint'($signed(r_cap)));

        // R7: restart mid-product; the abandoned product never completes.
        for (int j = 0; j < NPTS; j++) begin xb[j] = rnd_signed(XW); wb[j] = rnd_signed(WL); end
        for (int j = 0; j < NPTS; j++) begin xs[j] = rnd_signed(XW); ws[j] = rnd_signed(WL); end
        launch(xb, wb);
        early = 0;
        repeat (3) begin
            @(negedge clk);
            if (done) early++;
        end
        chk(early == 0, "R7 no done before restart", early, 0);
        launch(xs, ws);
        finish_op(xs, ws, "R7 restarted");

        // R3 R5 R8: random operands across the full signed ranges.
        for (int n = 0; n < 40; n++) begin
            for (int j = 0; j < NPTS; j++) begin
                xs[j] = rnd_signed(XW);
                ws[j] = rnd_signed(WL);
            end
            launch(xs, ws);
            finish_op(xs, ws, "random");
            if ((n % 4) == 0) repeat (2) @(negedge clk);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule